// File: doc/BRIEF.md
# Descriptor Table Lookup Unit

This unit keeps the location registers of three descriptor tables: a global table shared by all tasks, a per-task local table, and an interrupt table. It converts a 16-bit segment selector, or an 8-bit interrupt vector, into the linear address of an 8-byte descriptor. It checks that the whole descriptor lies inside the table limit and fetches it with two 32-bit reads on a simple request/response memory port. It then checks that the descriptor's type is one the table may hold and returns the 64-bit descriptor, or a fault with a kind and a code.

The global and interrupt table registers are written directly, each as a 32-bit base and a 16-bit limit. The local table is loaded differently. A load request carries a selector into the global table. The unit fetches the local-table descriptor found there, checks it, and caches its base and limit. Only one request is in flight at a time. While a request is in progress, new requests are dropped.

Top module: `desc_lookup_unit`

## Requirements
- R1: After reset `done_o`, `fault_o`, `busy_o` and `mem_req_o` are 0, `ldt_valid_o` is 0, and the cached local base and limit are 0.
- R2: A selector lookup (`req_op_i`=0) takes index = selector[15:3] and table = selector[2] (0 global, 1 local). It reads the 32-bit words at base+index*8 and then at base+index*8+4. The first word becomes descriptor bits 31:0. `done_o` rises one cycle after the clock edge that takes the second read response.
- R3: A vector lookup (`req_op_i`=1) reads interrupt-table base + vector*8 and applies the limit check to vector*8+7. Its fault code is the vector in bits 15:3, 0 in bit 2 and 1 in bit 1.
- R4: When index*8+7 exceeds the table limit, the lookup ends with fault kind 2 (limit). It issues no memory read and `done_o` is high in the cycle after acceptance.
- R5: Fault kind 1 (selector) is raised with no memory read, one cycle after acceptance, in three cases: a global selector with index 0 (any privilege bits), a local selector while no local table is loaded, and a local-table load whose selector has bit 2 set.
- R6: In the global table, interrupt gates (system types 6, 14) and trap gates (system types 7, 15) give fault kind 3 (type). Every other type passes. The type is read from descriptor byte 5: bit 4 set means code/data, and otherwise bits 3:0 are the system type.
- R7: In the local table only code/data descriptors, task gates (5) and call gates (4, 12) pass. Anything else gives fault kind 3.
- R8: In the interrupt table only task gates (5), interrupt gates (6, 14) and trap gates (7, 15) pass. Code/data descriptors and any other system type give fault kind 3.
- R9: A local-table load (`req_op_i`=2) succeeds only if the fetched descriptor is system type 2. The cached base is then {bits 63:56, bits 39:16} and the cached limit is bits 15:0. These values and `ldt_valid_o`=1 appear in the same cycle as `done_o`. A failed load leaves the cache unchanged.
- R10: A local-table load with a null selector (index 0, bit 2 clear) completes without a fault and without a memory read, and it clears `ldt_valid_o`.
- R11: For selector faults the fault code is selector[15:2] in bits 15:2 with bits 1:0 zero. `fault_code_o` is 0 whenever `fault_o` is 0. `desc_o` carries the fetched descriptor on any completion that read memory, including type faults, and is 0 otherwise.
- R12: Requests arriving while `busy_o` is high are ignored, and `req_op_i`=3 is never accepted. Neither produces a `done_o` pulse or a memory read.
- R13: Writes to the global or interrupt table register apply to every request accepted on a later clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| gdt_wr_i | input | 1 | Write global table base and limit |
| gdt_base_i | input | 32 | Global table base |
| gdt_limit_i | input | 16 | Global table limit |
| idt_wr_i | input | 1 | Write interrupt table base and limit |
| idt_base_i | input | 32 | Interrupt table base |
| idt_limit_i | input | 16 | Interrupt table limit |
| req_valid_i | input | 1 | Request strobe, taken when idle |
| req_op_i | input | 2 | 0 selector lookup, 1 vector lookup, 2 local-table load, 3 none |
| req_sel_i | input | 16 | Segment selector |
| req_vec_i | input | 8 | Interrupt vector |
| busy_o | output | 1 | Request in progress |
| mem_req_o | output | 1 | Read request, held until answered |
| mem_addr_o | output | 32 | Read address |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 32 | Read data |
| done_o | output | 1 | One-cycle completion pulse |
| fault_o | output | 1 | Completion is a fault |
| fault_kind_o | output | 2 | 1 selector, 2 limit, 3 type |
| fault_code_o | output | 16 | Offending index or vector |
| desc_o | output | 64 | Fetched descriptor |
| ldt_valid_o | output | 1 | A local table is loaded |
| ldt_base_o | output | 32 | Cached local table base |
| ldt_limit_o | output | 16 | Cached local table limit |

## Verification
Faults found before memory is touched (selector, limit, null load) complete in the first cycle after the accepting edge. Lookups that read memory complete in the cycle after the edge that takes the second response, however long the memory stalls. The bench records the edge on which each request is accepted and the edge on which its responder's last data is taken. It checks that `done_o` appears in exactly the expected cycle and that the read count matches: zero or two. The local-table cache is compared in the `done_o` cycle, and for ignored requests `done_o` and `mem_req_o` are watched for several cycles afterwards.

// File: rtl/desc_lookup_pkg.sv
package desc_lookup_pkg;

    localparam int ADDR_W = 32;
    localparam int LIM_W  = 16;
    localparam int SEL_W  = 16;
    localparam int VEC_W  = 8;
    localparam int WORD_W = 32;
    localparam int IDX_W  = SEL_W - 3;
    localparam int DESC_W = 2 * WORD_W;
    localparam int CODE_W = SEL_W;

    typedef enum logic [1:0] {
        OP_SEG  = 2'd0,
        OP_INT  = 2'd1,
        OP_LLDT = 2'd2,
        OP_NONE = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        TB_GLOBAL  = 2'd0,
        TB_LOCAL   = 2'd1,
        TB_INTR    = 2'd2,
        TB_LDTLOAD = 2'd3
    } tbl_e;

    typedef enum logic [1:0] {
        FK_NONE  = 2'd0,
        FK_SEL   = 2'd1,
        FK_LIMIT = 2'd2,
        FK_TYPE  = 2'd3
    } fkind_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RD0  = 2'd1,
        ST_RD1  = 2'd2
    } st_e;

    localparam logic [3:0] SYS_LDT      = 4'd2;
    localparam logic [3:0] SYS_CALL16   = 4'd4;
    localparam logic [3:0] SYS_TASKGATE = 4'd5;
    localparam logic [3:0] SYS_INT16    = 4'd6;
    localparam logic [3:0] SYS_TRAP16   = 4'd7;
    localparam logic [3:0] SYS_CALL32   = 4'd12;
    localparam logic [3:0] SYS_INT32    = 4'd14;
    localparam logic [3:0] SYS_TRAP32   = 4'd15;

endpackage

// File: rtl/dlu_addr_gen.sv
module dlu_addr_gen
    import desc_lookup_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int LW = LIM_W,
    parameter int IW = IDX_W
) (
    input  logic [AW-1:0] base_i,
    input  logic [LW-1:0] limit_i,
    input  logic [IW-1:0] idx_i,
    output logic [AW-1:0] addr_o,
    output logic          over_o
);
    localparam int OFF_W = IW + 3;
    localparam int CMP_W = (OFF_W + 1 > LW) ? OFF_W + 1 : LW;

    logic [CMP_W-1:0] last_off;
    logic [CMP_W-1:0] lim_ext;

    always_comb begin
        last_off = CMP_W'({idx_i, 3'b111});
        lim_ext  = CMP_W'(limit_i);
        over_o   = last_off > lim_ext;
        addr_o   = base_i + AW'({idx_i, 3'b000});
    end
endmodule

// File: rtl/dlu_type_check.sv
module dlu_type_check
    import desc_lookup_pkg::*;
(
    input  tbl_e       tbl_i,
    input  logic [7:0] acc_i,
    output logic       legal_o
);
    logic       is_seg;
    logic [3:0] sys_t;
    logic       is_int, is_trap, is_call, is_task, is_ldt;

    always_comb begin
        is_seg  = acc_i[4];
        sys_t   = acc_i[3:0];
        is_int  = !is_seg && (sys_t == SYS_INT16  || sys_t == SYS_INT32);
        is_trap = !is_seg && (sys_t == SYS_TRAP16 || sys_t == SYS_TRAP32);
        is_call = !is_seg && (sys_t == SYS_CALL16 || sys_t == SYS_CALL32);
        is_task = !is_seg && (sys_t == SYS_TASKGATE);
        is_ldt  = !is_seg && (sys_t == SYS_LDT);
        unique case (tbl_i)
            TB_GLOBAL:  legal_o = !(is_int || is_trap);
            TB_LOCAL:   legal_o = is_seg || is_task || is_call;
            TB_INTR:    legal_o = is_task || is_int || is_trap;
            TB_LDTLOAD: legal_o = is_ldt;
            default:    legal_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/dlu_table_regs.sv
module dlu_table_regs
    import desc_lookup_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int LW = LIM_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          gdt_wr_i,
    input  logic [AW-1:0] gdt_base_i,
    input  logic [LW-1:0] gdt_limit_i,
    input  logic          idt_wr_i,
    input  logic [AW-1:0] idt_base_i,
    input  logic [LW-1:0] idt_limit_i,
    input  logic          ldt_set_i,
    input  logic          ldt_clr_i,
    input  logic [AW-1:0] ldt_base_i,
    input  logic [LW-1:0] ldt_limit_i,
    output logic [AW-1:0] gdt_base_o,
    output logic [LW-1:0] gdt_limit_o,
    output logic [AW-1:0] idt_base_o,
    output logic [LW-1:0] idt_limit_o,
    output logic          ldt_valid_o,
    output logic [AW-1:0] ldt_base_o,
    output logic [LW-1:0] ldt_limit_o
);
    typedef struct packed {
        logic [AW-1:0] gb;
        logic [LW-1:0] gl;
        logic [AW-1:0] ib;
        logic [LW-1:0] il;
        logic          lv;
        logic [AW-1:0] lb;
        logic [LW-1:0] ll;
    } regs_s;

    regs_s regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (gdt_wr_i) begin
            regs_d.gb = gdt_base_i;
            regs_d.gl = gdt_limit_i;
        end
        if (idt_wr_i) begin
            regs_d.ib = idt_base_i;
            regs_d.il = idt_limit_i;
        end
        if (ldt_set_i) begin
            regs_d.lv = 1'b1;
            regs_d.lb = ldt_base_i;
            regs_d.ll = ldt_limit_i;
        end else if (ldt_clr_i) begin
            regs_d.lv = 1'b0;
            regs_d.lb = '0;
            regs_d.ll = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign gdt_base_o  = regs_q.gb;
    assign gdt_limit_o = regs_q.gl;
    assign idt_base_o  = regs_q.ib;
    assign idt_limit_o = regs_q.il;
    assign ldt_valid_o = regs_q.lv;
    assign ldt_base_o  = regs_q.lb;
    assign ldt_limit_o = regs_q.ll;

    // R10
    ldt_set_clr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ldt_set_i |-> !ldt_clr_i);
endmodule

// File: rtl/desc_lookup_unit.sv
module desc_lookup_unit
    import desc_lookup_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                gdt_wr_i,
    input  logic [ADDR_W-1:0]   gdt_base_i,
    input  logic [LIM_W-1:0]    gdt_limit_i,
    input  logic                idt_wr_i,
    input  logic [ADDR_W-1:0]   idt_base_i,
    input  logic [LIM_W-1:0]    idt_limit_i,
    input  logic                req_valid_i,
    input  logic [1:0]          req_op_i,
    input  logic [SEL_W-1:0]    req_sel_i,
    input  logic [VEC_W-1:0]    req_vec_i,
    output logic                busy_o,
    output logic                mem_req_o,
    output logic [ADDR_W-1:0]   mem_addr_o,
    input  logic                mem_rvalid_i,
    input  logic [WORD_W-1:0]   mem_rdata_i,
    output logic                done_o,
    output logic                fault_o,
    output logic [1:0]          fault_kind_o,
    output logic [CODE_W-1:0]   fault_code_o,
    output logic [DESC_W-1:0]   desc_o,
    output logic                ldt_valid_o,
    output logic [ADDR_W-1:0]   ldt_base_o,
    output logic [LIM_W-1:0]    ldt_limit_o
);
    localparam int ACC_LSB = 8;

    typedef struct packed {
        st_e                st;
        tbl_e               tbl;
        logic [ADDR_W-1:0]  addr;
        logic [WORD_W-1:0]  lo;
        logic [CODE_W-1:0]  code;
        logic               done;
        fkind_e             kind;
        logic [DESC_W-1:0]  desc;
    } core_s;

    core_s core_d, core_q;

    logic [ADDR_W-1:0] gdt_base, idt_base, tbl_base, gen_addr;
    logic [LIM_W-1:0]  gdt_limit, idt_limit, tbl_limit;
    logic [IDX_W-1:0]  req_idx;
    logic              over_lim;
    tbl_e              req_tbl;
    logic [CODE_W-1:0] req_code;
    logic              sel_bad, lldt_null, req_take;
    logic              type_ok;
    logic              ldt_set, ldt_clr;
    logic [DESC_W-1:0] full_desc;
    logic [ADDR_W-1:0] new_ldt_base;
    logic [LIM_W-1:0]  new_ldt_limit;
    op_e               op;

    dlu_table_regs u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .gdt_wr_i    (gdt_wr_i),
        .gdt_base_i  (gdt_base_i),
        .gdt_limit_i (gdt_limit_i),
        .idt_wr_i    (idt_wr_i),
        .idt_base_i  (idt_base_i),
        .idt_limit_i (idt_limit_i),
        .ldt_set_i   (ldt_set),
        .ldt_clr_i   (ldt_clr),
        .ldt_base_i  (new_ldt_base),
        .ldt_limit_i (new_ldt_limit),
        .gdt_base_o  (gdt_base),
        .gdt_limit_o (gdt_limit),
        .idt_base_o  (idt_base),
        .idt_limit_o (idt_limit),
        .ldt_valid_o (ldt_valid_o),
        .ldt_base_o  (ldt_base_o),
        .ldt_limit_o (ldt_limit_o)
    );

    // request decode: table, index, code and bases
    always_comb begin
        op       = op_e'(req_op_i);
        req_idx  = req_sel_i[SEL_W-1:3];
        req_tbl  = TB_GLOBAL;
        req_code = {req_sel_i[SEL_W-1:2], 2'b00};
        sel_bad  = 1'b0;
        lldt_null = 1'b0;
        unique case (op)
            OP_SEG: begin
                req_tbl = req_sel_i[2] ? TB_LOCAL : TB_GLOBAL;
                sel_bad = req_sel_i[2] ? !ldt_valid_o : (req_idx == '0);
            end
            OP_INT: begin
                req_tbl  = TB_INTR;
                req_idx  = IDX_W'(req_vec_i);
                req_code = {IDX_W'(req_vec_i), 3'b010};
            end
            OP_LLDT: begin
                req_tbl   = TB_LDTLOAD;
                sel_bad   = req_sel_i[2];
                lldt_null = !req_sel_i[2] && (req_idx == '0);
            end
            default: ;
        endcase
        unique case (req_tbl)
            TB_LOCAL: begin tbl_base = ldt_base_o; tbl_limit = ldt_limit_o; end
            TB_INTR:  begin tbl_base = idt_base;   tbl_limit = idt_limit;   end
            default:  begin tbl_base = gdt_base;   tbl_limit = gdt_limit;   end
        endcase
    end

    dlu_addr_gen u_addr (
        .base_i  (tbl_base),
        .limit_i (tbl_limit),
        .idx_i   (req_idx),
        .addr_o  (gen_addr),
        .over_o  (over_lim)
    );

    assign full_desc = {mem_rdata_i, core_q.lo};

    dlu_type_check u_type (
        .tbl_i   (core_q.tbl),
        .acc_i   (mem_rdata_i[ACC_LSB +: 8]),
        .legal_o (type_ok)
    );

    always_comb begin
        new_ldt_base  = {full_desc[63:56], full_desc[39:16]};
        new_ldt_limit = full_desc[LIM_W-1:0];
    end

    // next-state logic
    always_comb begin
        core_d      = core_q;
        core_d.done = 1'b0;
        core_d.kind = FK_NONE;
        core_d.desc = '0;
        ldt_set     = 1'b0;
        ldt_clr     = 1'b0;
        req_take    = req_valid_i && (op != OP_NONE);
        unique case (core_q.st)
            ST_IDLE: begin
                if (req_take) begin
                    core_d.code = req_code;
                    core_d.tbl  = req_tbl;
                    core_d.addr = gen_addr;
                    if (sel_bad) begin
                        core_d.done = 1'b1;
                        core_d.kind = FK_SEL;
                    end else if (lldt_null) begin
                        core_d.done = 1'b1;
                        ldt_clr     = 1'b1;
                    end else if (over_lim) begin
                        core_d.done = 1'b1;
                        core_d.kind = FK_LIMIT;
                    end else begin
                        core_d.st = ST_RD0;
                    end
                end
            end
            ST_RD0: begin
                if (mem_rvalid_i) begin
                    core_d.lo = mem_rdata_i;
                    core_d.st = ST_RD1;
                end
            end
            ST_RD1: begin
                if (mem_rvalid_i) begin
                    core_d.desc = full_desc;
                    core_d.done = 1'b1;
                    core_d.st   = ST_IDLE;
                    if (!type_ok)                      core_d.kind = FK_TYPE;
                    else if (core_q.tbl == TB_LDTLOAD) ldt_set     = 1'b1;
                end
            end
            default: core_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) core_q <= '0;
        else        core_q <= core_d;
    end

    always_comb begin
        busy_o       = core_q.st != ST_IDLE;
        mem_req_o    = busy_o;
        mem_addr_o   = core_q.addr + ((core_q.st == ST_RD1) ? ADDR_W'(4) : ADDR_W'(0));
        done_o       = core_q.done;
        fault_o      = core_q.kind != FK_NONE;
        fault_kind_o = core_q.kind;
        fault_code_o = fault_o ? core_q.code : '0;
        desc_o       = core_q.desc;
    end

    // R2
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (core_q.st == ST_RD0 && mem_rvalid_i) |=> (mem_req_o && mem_addr_o == $past(mem_addr_o) + ADDR_W'(4)));

    // R2
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_rvalid_i) |=> (mem_req_o && $stable(mem_addr_o)));

    // R4
    early_fault_noread_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && fault_o && fault_kind_o != FK_TYPE) |-> !$past(mem_req_o));

    // R6
    type_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && fault_kind_o == FK_TYPE) |-> $past(mem_req_o && mem_rvalid_i));

    // R9
    ldt_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({ldt_valid_o, ldt_base_o, ldt_limit_o}) |-> done_o);

    // R12
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !mem_req_o);

    // R11
    code_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fault_o |-> (fault_code_o == '0));
endmodule

// File: tb/desc_lookup_unit_bench.sv
`timescale 1ns/1ps
module desc_lookup_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        gdt_wr = 1'b0, idt_wr = 1'b0;
    logic [31:0] gdt_base = '0, idt_base = '0;
    logic [15:0] gdt_limit = '0, idt_limit = '0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_op = 2'd3;
    logic [15:0] req_sel = '0;
    logic [7:0]  req_vec = '0;
    logic        busy, mem_req, done, fault, ldt_valid;
    logic [31:0] mem_addr, ldt_base;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic [1:0]  fault_kind;
    logic [15:0] fault_code, ldt_limit;
    logic [63:0] desc;

    desc_lookup_unit u_desc_lookup_unit (
        .clk(clk), .rst_n(rst_n),
        .gdt_wr_i(gdt_wr), .gdt_base_i(gdt_base), .gdt_limit_i(gdt_limit),
        .idt_wr_i(idt_wr), .idt_base_i(idt_base), .idt_limit_i(idt_limit),
        .req_valid_i(req_valid), .req_op_i(req_op), .req_sel_i(req_sel), .req_vec_i(req_vec),
        .busy_o(busy), .mem_req_o(mem_req), .mem_addr_o(mem_addr),
        .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata),
        .done_o(done), .fault_o(fault), .fault_kind_o(fault_kind), .fault_code_o(fault_code),
        .desc_o(desc), .ldt_valid_o(ldt_valid), .ldt_base_o(ldt_base), .ldt_limit_o(ldt_limit)
    );

    always #5 clk = ~clk;

    int unsigned tests = 0, fails = 0;
    int unsigned cyc = 0, last_rv_cyc = 0, nreads = 0, lat_max = 2, wcnt = 0;
    bit          finished = 1'b0;
    logic [31:0] mem [0:255];

    // bench model of table registers
    logic [31:0] m_gb = '0, m_ib = '0, m_lb = '0;
    logic [15:0] m_gl = '0, m_il = '0, m_ll = '0;
    logic        m_lv = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    // memory responder: random latency, one response per request beat
    always @(negedge clk) begin
        if (!rst_n) begin
            mem_rvalid <= 1'b0;
            wcnt <= 0;
        end else if (mem_rvalid) begin
            mem_rvalid <= 1'b0;
            wcnt <= $urandom_range(lat_max, 0);
        end else if (mem_req) begin
            if (wcnt == 0) begin
                mem_rvalid  <= 1'b1;
                mem_rdata   <= mem[mem_addr[9:2]];
                nreads      <= nreads + 1;
                last_rv_cyc <= cyc + 1;
            end else begin
                wcnt <= wcnt - 1;
            end
        end
    end

    task automatic check(input string req, input string what, input logic [63:0] got, input logic [63:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
        end
    endtask

    function automatic bit legal_type(input logic [1:0] tb, input logic [7:0] acc);
        logic s = acc[4];
        logic [3:0] t = acc[3:0];
        case (tb)
            2'd0: return s || !(t == 6 || t == 7 || t == 14 || t == 15);
            2'd1: return s || t == 5 || t == 4 || t == 12;
            2'd2: return !s && (t == 5 || t == 6 || t == 7 || t == 14 || t == 15);
            default: return !s && t == 2;
        endcase
    endfunction

    task automatic step();
        @(negedge clk); #1;
    endtask

    task automatic put_desc(input logic [31:0] a, input logic [31:0] lo, input logic [31:0] hi);
        logic [31:0] a4 = a + 4;
        mem[a[9:2]]  = lo;
        mem[a4[9:2]] = hi;
    endtask

    task automatic write_gdt(input logic [31:0] b, input logic [15:0] l);
        gdt_wr = 1'b1; gdt_base = b; gdt_limit = l;
        step();
        gdt_wr = 1'b0;
        m_gb = b; m_gl = l;
    endtask

    task automatic write_idt(input logic [31:0] b, input logic [15:0] l);
        idt_wr = 1'b1; idt_base = b; idt_limit = l;
        step();
        idt_wr = 1'b0;
        m_ib = b; m_il = l;
    endtask

    task automatic run_op(input logic [1:0] op, input logic [15:0] sel, input logic [7:0] vec, input bit inject);
        logic [12:0] idx = sel[15:3];
        logic [31:0] base, a, a4;
        logic [15:0] lim, e_code;
        logic [1:0]  e_kind = 2'd0, tb = 2'd0;
        logic [63:0] e_desc = '0;
        int unsigned e_reads = 0, r0, acc_cyc, guard;
        bit decided = 1'b0, e_set = 1'b0, e_clr = 1'b0;
        logic [31:0] e_lb = m_lb;
        logic [15:0] e_ll = m_ll;
        logic        e_lv = m_lv;
        string       rq;

        e_code = (op == 2'd1) ? {5'b0, vec, 3'b010} : {sel[15:2], 2'b00};
        rq = (op == 2'd1) ? "R3" : ((op == 2'd2) ? "R9" : "R2");
        base = m_gb; lim = m_gl;
        if (op == 2'd0) begin
            if (!sel[2] && idx == 0)      begin e_kind = 2'd1; decided = 1'b1; rq = "R5"; end
            else if (sel[2] && !m_lv)     begin e_kind = 2'd1; decided = 1'b1; rq = "R5"; end
            else if (sel[2]) begin base = m_lb; lim = m_ll; tb = 2'd1; end
        end else if (op == 2'd1) begin
            idx = {5'b0, vec}; base = m_ib; lim = m_il; tb = 2'd2;
        end else begin
            tb = 2'd3;
            if (sel[2])        begin e_kind = 2'd1; decided = 1'b1; rq = "R5"; end
            else if (idx == 0) begin decided = 1'b1; e_clr = 1'b1; rq = "R10"; end
        end
        if (!decided) begin
            if ({1'b0, idx, 3'b111} > {1'b0, lim}) begin
                e_kind = 2'd2; rq = "R4";
            end else begin
                a = base + {16'b0, idx, 3'b000};
                a4 = a + 4;
                e_desc = {mem[a4[9:2]], mem[a[9:2]]};
                e_reads = 2;
                if (!legal_type(tb, e_desc[47:40])) begin
                    e_kind = 2'd3;
                    rq = (tb == 2'd0) ? "R6" : (tb == 2'd1) ? "R7" : (tb == 2'd2) ? "R8" : "R9";
                end else if (tb == 2'd3) begin
                    e_set = 1'b1;
                end
            end
        end
        if (e_set) begin e_lv = 1'b1; e_lb = {e_desc[63:56], e_desc[39:16]}; e_ll = e_desc[15:0]; end
        if (e_clr) begin e_lv = 1'b0; e_lb = '0; e_ll = '0; end

        r0 = nreads;
        req_valid = 1'b1; req_op = op; req_sel = sel; req_vec = vec;
        step();
        req_valid = 1'b0; req_op = 2'd3;
        acc_cyc = cyc;
        guard = 0;
        while (!done && guard < 60) begin
            if (inject && guard == 0) begin
                req_valid = 1'b1; req_op = 2'd0; req_sel = 16'h0000;
            end
            step();
            req_valid = 1'b0; req_op = 2'd3;
            guard++;
        end
        check(rq, "done seen", {63'b0, done}, 64'd1);
        if (done) begin
            check("R2", "done cycle", 64'(cyc), 64'(e_reads != 0 ? last_rv_cyc : acc_cyc));
            check(rq, "fault", {63'b0, fault}, {63'b0, e_kind != 2'd0});
            check(rq, "fault kind", {62'b0, fault_kind}, {62'b0, e_kind});
            check("R11", "fault code", {48'b0, fault_code}, {48'b0, (e_kind != 0) ? e_code : 16'h0});
            check("R11", "descriptor", desc, e_desc);
            check(rq, "read count", 64'(nreads - r0), 64'(e_reads));
            check("R9", "ldt cache", {15'b0, ldt_valid, ldt_base, ldt_limit}, {15'b0, e_lv, e_lb, e_ll});
        end
        m_lv = e_lv; m_lb = e_lb; m_ll = e_ll;
        if (inject) begin
            for (int k = 0; k < 3; k++) begin
                step();
                check("R12", "no extra done", {62'b0, done, mem_req}, 64'd0);
            end
        end
    endtask

    task automatic fill_random();
        for (int k = 0; k < 128; k++) begin
            logic [31:0] lo = $urandom, hi = $urandom;
            logic [3:0]  t = 4'($urandom_range(15, 0));
            logic        s = ($urandom_range(2, 0) == 0);
            hi[15:8] = ($urandom_range(3, 0) == 0) ? 8'h82 : {3'b100, s, t};
            mem[2*k] = lo; mem[2*k+1] = hi;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            tests++; fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        for (int k = 0; k < 256; k++) mem[k] = '0;
        repeat (3) @(negedge clk);
        #1;
        rst_n = 1'b1;
        step();
        // R1 reset state
        check("R1", "reset outputs", {59'b0, done, fault, busy, mem_req, ldt_valid}, 64'd0);
        check("R1", "reset ldt", {16'b0, ldt_base, ldt_limit}, 64'd0);

        write_gdt(32'h100, 16'h3F);
        write_idt(32'h200, 16'hFF);
        put_desc(32'h108, 32'h1234_FFFF, 32'h00CF_9A00);
        put_desc(32'h110, 32'h0008_0000, 32'h0000_8E00);
        put_desc(32'h118, 32'h0300_0017, 32'h0000_8200);
        put_desc(32'h120, 32'h4000_0067, 32'h0000_8900);
        put_desc(32'h138, 32'h5555_0000, 32'h0000_9200);
        put_desc(32'h300, 32'h0000_FFFF, 32'h00CF_9A00);
        put_desc(32'h308, 32'h0010_2000, 32'h0000_8C00);
        put_desc(32'h310, 32'h0020_0067, 32'h0000_8900);
        put_desc(32'h2F8, 32'h0008_3000, 32'h0000_8F00);
        put_desc(32'h218, 32'h0000_FFFF, 32'h00CF_9A00);
        put_desc(32'h228, 32'h0030_0000, 32'h0000_8500);

        run_op(2'd0, 16'h0008, 8'h0, 1'b0); // R2 global code
        run_op(2'd0, 16'h0000, 8'h0, 1'b0); // R5 null
        run_op(2'd0, 16'h0003, 8'h0, 1'b0); // R5 null with privilege bits
        run_op(2'd0, 16'h0038, 8'h0, 1'b0); // R4 last entry at limit
        run_op(2'd0, 16'h0040, 8'h0, 1'b0); // R4 one past limit
        run_op(2'd0, 16'h0010, 8'h0, 1'b0); // R6 interrupt gate in global
        run_op(2'd0, 16'h000C, 8'h0, 1'b0); // R5 local before load
        run_op(2'd2, 16'h001C, 8'h0, 1'b0); // R5 load with local selector
        run_op(2'd2, 16'h0020, 8'h0, 1'b0); // R9 load of wrong type
        run_op(2'd2, 16'h0018, 8'h0, 1'b0); // R9 load succeeds
        run_op(2'd0, 16'h0004, 8'h0, 1'b0); // R7 local index 0 allowed
        run_op(2'd0, 16'h000F, 8'h0, 1'b0); // R7 call gate
        run_op(2'd0, 16'h0014, 8'h0, 1'b0); // R7 task state in local
        run_op(2'd0, 16'h001C, 8'h0, 1'b0); // R4 local limit
        run_op(2'd1, 16'h0, 8'd31, 1'b0);   // R3 last reserved vector
        run_op(2'd1, 16'h0, 8'd32, 1'b0);   // R3 past limit
        run_op(2'd1, 16'h0, 8'd3, 1'b0);    // R8 code in interrupt table
        run_op(2'd1, 16'h0, 8'd5, 1'b0);    // R8 task gate
        lat_max = 4;
        run_op(2'd0, 16'h0008, 8'h0, 1'b1); // R12 request while busy
        lat_max = 2;
        // R12 op 3 never accepted
        req_valid = 1'b1; req_op = 2'd3; req_sel = 16'h0000;
        step();
        req_valid = 1'b0;
        for (int k = 0; k < 3; k++) begin
            check("R12", "op3 ignored", {62'b0, done, mem_req}, 64'd0);
            step();
        end
        run_op(2'd2, 16'h0000, 8'h0, 1'b0); // R10 null load
        run_op(2'd0, 16'h000C, 8'h0, 1'b0); // R10 local now null
        write_gdt(32'h180, 16'h3F);          // R13 moved table
        put_desc(32'h188, 32'hABCD_0000, 32'h0000_9300);
        run_op(2'd0, 16'h0008, 8'h0, 1'b0);

        for (int it = 0; it < 400; it++) begin
            if (it % 40 == 0) begin
                fill_random();
                write_gdt({22'b0, 7'($urandom_range(127, 0)), 3'b000}, 16'($urandom_range(192, 40)));
                write_idt({22'b0, 7'($urandom_range(127, 0)), 3'b000}, 16'($urandom_range(300, 100)));
            end
            begin
                logic [1:0]  op = 2'($urandom_range(2, 0));
                logic [15:0] sel = {3'b0, 10'($urandom_range(24, 0)), 1'($urandom_range(1, 0)), 2'($urandom_range(3, 0))};
                logic [7:0]  vec = 8'($urandom_range(40, 0));
                run_op(op, sel, vec, ($urandom_range(15, 0) == 0));
            end
        end

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule